// File: doc/BRIEF.md
# Dual-Channel Bus-Master DMA Register Front End

This block holds the software-visible registers of a two-channel bus-master disk DMA controller. They are reached through a 16-byte I/O window. A simple register bus carries a 4-bit offset, an access size in bytes (1, 2 or 4), write data, and read and write strobes. Each channel has three registers:

- a command byte, carrying start/stop and transfer direction;
- a status byte, which mixes software-written, write-one-to-clear and engine-owned bits;
- a 32-bit, word-aligned descriptor-table pointer.

The DMA engine drives the active level and the error and interrupt set pulses. It reads the command bits and both pointers directly from the block's outputs.

Read data is combinational while `bus_rd` is high and is returned right-justified. The command/status half of each channel accepts only byte accesses. Wider reads there return all ones across the requested width, and wider writes there are dropped. The pointer accepts any of the three sizes on naturally placed byte lanes.

Top module: `bmdma_regs`

## Requirements
- R1: Channel c occupies offsets 8c to 8c+7. The command byte is at +0, status at +2 and the pointer at +4 to +7. Offset bit 3 selects the channel and bit 2 selects the pointer half.
- R2: A byte read at sub-block offset +1 or +3 returns 0x000000FF.
- R3: A read of the command/status sub-block with size 2 returns 0x0000FFFF, and with size 4 returns 0xFFFFFFFF.
- R4: A write of size 2 or 4 to the command/status sub-block changes no register.
- R5: A byte write to command stores bit 0 (start, driven on `cmd_start[c]`) and bit 3 (direction, driven on `cmd_dir[c]`). All other command bits read as 0.
- R6: A byte write to status has the following effect. Bits 6 and 5 take the written value. Bits 2 and 1 are cleared where the written bit is 1 and kept where it is 0. Bit 0 keeps its value. Bits 7, 4 and 3 read as 0.
- R7: Status bit 0 shows `eng_active[c]` as sampled at the previous clock edge.
- R8: A one-cycle pulse on `eng_err_set[c]` sets status bit 1, and a pulse on `eng_irq_set[c]` sets status bit 2. If a set and a write-one-to-clear of the same bit fall in the same cycle, the bit ends up set.
- R9: The pointer accepts 1-, 2- and 4-byte accesses:
  - A byte access uses lane offset[1:0].
  - A 2-byte access uses the half chosen by offset[1].
  - Write data is taken from the low bits.
  - Read data is right-justified, with unused upper bits 0.
  - `desc_ptr` carries {channel 1, channel 0}.
- R10: Pointer bits [1:0] are always 0.
- R11: A synchronous active-high reset clears command, status and pointer of both channels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Offset within the window |
| bus_size | input | 3 | Access size in bytes (1, 2 or 4) |
| bus_wdata | input | 32 | Write data, right-justified |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, right-justified, 0 when idle |
| eng_active | input | 2 | Per-channel engine active level |
| eng_err_set | input | 2 | Per-channel error set pulse |
| eng_irq_set | input | 2 | Per-channel interrupt set pulse |
| cmd_start | output | 2 | Per-channel start/stop bit |
| cmd_dir | output | 2 | Per-channel direction bit |
| desc_ptr | output | 64 | Descriptor pointers, channel 1 in the upper word |

## Verification
The hardest case to reach is a collision on the same status bit in one cycle: an engine set pulse and a software write-one-to-clear. The bench produces it by raising `eng_irq_set` and the bus write strobe on the same falling edge and dropping both on the next. It then reads status back to confirm the bit survived. Afterwards a lone clear confirms that the same write would otherwise have removed it. The preserved active bit is checked the same way: status is written while `eng_active` is held high.

// File: rtl/bmdma_regs.sv
module bmdma_regs (
  input  logic        clk,
  input  logic        rst,
  input  logic [3:0]  bus_addr,
  input  logic [2:0]  bus_size,
  input  logic [31:0] bus_wdata,
  input  logic        bus_wr,
  input  logic        bus_rd,
  output logic [31:0] bus_rdata,
  input  logic [1:0]  eng_active,
  input  logic [1:0]  eng_err_set,
  input  logic [1:0]  eng_irq_set,
  output logic [1:0]  cmd_start,
  output logic [1:0]  cmd_dir,
  output logic [63:0] desc_ptr
);
  localparam int NCH = 2;

  logic [NCH-1:0]       run_q, dir_q, act_q, err_q, irq_q, b5_q, b6_q;
  logic [NCH-1:0][31:0] ptr_q;

  logic       ch;
  logic       in_ptr;
  logic [1:0] lane;
  logic       is_byte;
  logic [3:0] be;
  logic [31:0] wrep;

  assign ch      = bus_addr[3];
  assign in_ptr  = bus_addr[2];
  assign lane    = bus_addr[1:0];
  assign is_byte = (bus_size == 3'd1);

  always_comb begin
    case (bus_size)
      3'd1:    be = 4'b0001 << lane;
      3'd2:    be = lane[1] ? 4'b1100 : 4'b0011;
      3'd4:    be = 4'b1111;
      default: be = 4'b0000;
    endcase
    case (bus_size)
      3'd1:    wrep = {4{bus_wdata[7:0]}};
      3'd2:    wrep = {2{bus_wdata[15:0]}};
      default: wrep = bus_wdata;
    endcase
  end

  logic cmd_hit, sts_hit;
  assign cmd_hit = bus_wr && !in_ptr && is_byte && (lane == 2'd0);
  assign sts_hit = bus_wr && !in_ptr && is_byte && (lane == 2'd2);

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= '0;
      dir_q <= '0;
      act_q <= '0;
      err_q <= '0;
      irq_q <= '0;
      b5_q  <= '0;
      b6_q  <= '0;
      ptr_q <= '0;
    end else begin
      act_q <= eng_active;
      for (int c = 0; c < NCH; c++) begin
        if (cmd_hit && ch == c[0]) begin
          run_q[c] <= bus_wdata[0];
          dir_q[c] <= bus_wdata[3];
        end
        if (sts_hit && ch == c[0]) begin
          b5_q[c] <= bus_wdata[5];
          b6_q[c] <= bus_wdata[6];
        end
        err_q[c] <= eng_err_set[c] |
                    (err_q[c] & ~(sts_hit && ch == c[0] && bus_wdata[1]));
        irq_q[c] <= eng_irq_set[c] |
                    (irq_q[c] & ~(sts_hit && ch == c[0] && bus_wdata[2]));
        for (int b = 0; b < 4; b++) begin
          if (bus_wr && in_ptr && ch == c[0] && be[b])
            ptr_q[c][8*b +: 8] <= wrep[8*b +: 8] & ((b == 0) ? 8'hFC : 8'hFF);
        end
      end
    end
  end

  logic [7:0]  cmd_byte, sts_byte;
  logic [31:0] pv;
  assign cmd_byte = {4'b0, dir_q[ch], 2'b0, run_q[ch]};
  assign sts_byte = {1'b0, b6_q[ch], b5_q[ch], 2'b0, irq_q[ch], err_q[ch], act_q[ch]};
  assign pv       = ptr_q[ch];

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      if (!in_ptr) begin
        case (bus_size)
          3'd1: case (lane)
                  2'd0:    bus_rdata = {24'h0, cmd_byte};
                  2'd2:    bus_rdata = {24'h0, sts_byte};
                  default: bus_rdata = 32'h0000_00FF;
                endcase
          3'd2:    bus_rdata = 32'h0000_FFFF;
          3'd4:    bus_rdata = 32'hFFFF_FFFF;
          default: bus_rdata = '0;
        endcase
      end else begin
        case (bus_size)
          3'd1:    bus_rdata = {24'h0, pv[8*lane +: 8]};
          3'd2:    bus_rdata = {16'h0, lane[1] ? pv[31:16] : pv[15:0]};
          3'd4:    bus_rdata = pv;
          default: bus_rdata = '0;
        endcase
      end
    end
  end

  assign cmd_start = run_q;
  assign cmd_dir   = dir_q;
  assign desc_ptr  = {ptr_q[1], ptr_q[0]};
endmodule

// File: rtl/bmdma_regs_chk.sv
module bmdma_regs_chk (
  input logic        clk,
  input logic        rst,
  input logic [3:0]  bus_addr,
  input logic [2:0]  bus_size,
  input logic [31:0] bus_wdata,
  input logic        bus_wr,
  input logic        bus_rd,
  input logic [31:0] bus_rdata,
  input logic [1:0]  eng_err_set,
  input logic [1:0]  eng_irq_set,
  input logic [1:0]  cmd_start,
  input logic [1:0]  cmd_dir,
  input logic [63:0] desc_ptr,
  input logic [1:0]  err_q,
  input logic [1:0]  irq_q
);
  // R2
  pad_rd_chk: assert property (@(posedge clk) disable iff (rst)
    bus_rd && !bus_addr[2] && bus_size == 3'd1 && bus_addr[0] |-> bus_rdata == 32'h0000_00FF);
  // R3
  wide_rd_chk: assert property (@(posedge clk) disable iff (rst)
    bus_rd && !bus_addr[2] && bus_size == 3'd4 |-> bus_rdata == 32'hFFFF_FFFF);
  // R4
  cmd_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    bus_wr && !bus_addr[2] && bus_size != 3'd1 |=> $stable(cmd_start) && $stable(cmd_dir));
  // R5
  cmd_wr_chk: assert property (@(posedge clk) disable iff (rst)
    bus_wr && bus_addr == 4'h0 && bus_size == 3'd1 |=> cmd_start[0] == $past(bus_wdata[0]));
  // R8
  err_set_chk: assert property (@(posedge clk) disable iff (rst)
    eng_err_set[0] |=> err_q[0]);
  // R8
  irq_set_chk: assert property (@(posedge clk) disable iff (rst)
    eng_irq_set[1] |=> irq_q[1]);
  // R11
  reset_chk: assert property (@(posedge clk)
    rst |=> cmd_start == 2'b00 && cmd_dir == 2'b00 && desc_ptr == 64'h0);
endmodule

bind bmdma_regs bmdma_regs_chk chk_i (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_size(bus_size),
  .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
  .eng_err_set(eng_err_set), .eng_irq_set(eng_irq_set), .cmd_start(cmd_start),
  .cmd_dir(cmd_dir), .desc_ptr(desc_ptr), .err_q(err_q), .irq_q(irq_q)
);

// File: tb/bmdma_regs_tb_top.sv
module bmdma_regs_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  bus_addr = '0;
  logic [2:0]  bus_size = 3'd1;
  logic [31:0] bus_wdata = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic [1:0]  eng_active = '0, eng_err_set = '0, eng_irq_set = '0;
  logic [1:0]  cmd_start, cmd_dir;
  logic [63:0] desc_ptr;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  bmdma_regs dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_size(bus_size),
    .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .eng_active(eng_active), .eng_err_set(eng_err_set), .eng_irq_set(eng_irq_set),
    .cmd_start(cmd_start), .cmd_dir(cmd_dir), .desc_ptr(desc_ptr)
  );

  // {is_write, addr, size, data, expected read}
  localparam int NV = 22;
  localparam logic [71:0] VEC [NV] = '{
    {1'b1, 4'h0, 3'd1, 32'h0000_00FF, 32'h0},           // R5 cmd0 <- 0x09
    {1'b0, 4'h0, 3'd1, 32'h0, 32'h0000_0009},           // R5
    {1'b0, 4'h1, 3'd1, 32'h0, 32'h0000_00FF},           // R2
    {1'b0, 4'h3, 3'd1, 32'h0, 32'h0000_00FF},           // R2
    {1'b0, 4'h0, 3'd2, 32'h0, 32'h0000_FFFF},           // R3
    {1'b0, 4'h0, 3'd4, 32'h0, 32'hFFFF_FFFF},           // R3
    {1'b0, 4'hA, 3'd4, 32'h0, 32'hFFFF_FFFF},           // R3
    {1'b1, 4'h0, 3'd2, 32'h0000_0000, 32'h0},           // R4
    {1'b1, 4'h0, 3'd4, 32'h0000_0000, 32'h0},           // R4
    {1'b0, 4'h0, 3'd1, 32'h0, 32'h0000_0009},           // R4
    {1'b1, 4'h2, 3'd1, 32'h0000_00FF, 32'h0},           // R6
    {1'b0, 4'h2, 3'd1, 32'h0, 32'h0000_0060},           // R6
    {1'b1, 4'h8, 3'd1, 32'h0000_0008, 32'h0},           // R1
    {1'b0, 4'h8, 3'd1, 32'h0, 32'h0000_0008},           // R1
    {1'b0, 4'h0, 3'd1, 32'h0, 32'h0000_0009},           // R1
    {1'b1, 4'h4, 3'd4, 32'h1234_5677, 32'h0},           // R10
    {1'b0, 4'h4, 3'd4, 32'h0, 32'h1234_5674},           // R10
    {1'b1, 4'hC, 3'd1, 32'h0000_00AB, 32'h0},           // R9 / R10
    {1'b1, 4'hE, 3'd2, 32'h0000_BEEF, 32'h0},           // R9
    {1'b0, 4'hC, 3'd4, 32'h0, 32'hBEEF_00A8},           // R9
    {1'b0, 4'hE, 3'd2, 32'h0, 32'h0000_BEEF},           // R9
    {1'b0, 4'h7, 3'd1, 32'h0, 32'h0000_0012}            // R9
  };

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [2:0] s, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_size = s; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [2:0] s, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_size = s; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R11 reset state
    chk("R11 outputs", {cmd_start, cmd_dir}, 4'b0);
    chk("R11 ptr", desc_ptr, 64'h0);
    rd(4'h2, 3'd1, d); chk("R11 status", d, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][71]) wr(VEC[i][70:67], VEC[i][66:64], VEC[i][63:32]);
      else begin
        rd(VEC[i][70:67], VEC[i][66:64], d);
        chk($sformatf("vector %0d", i), d, VEC[i][31:0]);
      end
    end

    // R5 engine-facing command outputs
    chk("R5 cmd_start", cmd_start, 2'b01);
    chk("R5 cmd_dir", cmd_dir, 2'b11);
    // R9 pointer outputs
    chk("R9 desc_ptr", desc_ptr, 64'hBEEF_00A8_1234_5674);
    rd(4'hD, 3'd1, d); chk("R9 byte lane 1", d, 32'h0);

    // R7 active follows engine
    @(negedge clk); eng_active = 2'b01;
    rd(4'h2, 3'd1, d); chk("R7 active", d, 32'h61);
    // R6 bit 0 kept, bits 6/5 written
    wr(4'h2, 3'd1, 32'h0000_0000);
    rd(4'h2, 3'd1, d); chk("R6 keep active", d, 32'h01);

    // R8 set pulses
    @(negedge clk); eng_err_set = 2'b01; @(negedge clk); eng_err_set = 2'b00;
    rd(4'h2, 3'd1, d); chk("R8 err set", d, 32'h03);
    @(negedge clk); eng_irq_set = 2'b01; @(negedge clk); eng_irq_set = 2'b00;
    rd(4'h2, 3'd1, d); chk("R8 irq set", d, 32'h07);
    wr(4'h2, 3'd1, 32'h0000_0002);
    rd(4'h2, 3'd1, d); chk("R6 w1c err", d, 32'h05);
    rd(4'hA, 3'd1, d); chk("R1 other channel status", d, 32'h00);
    // R8 collision: set wins
    @(negedge clk);
    eng_irq_set = 2'b01; bus_addr = 4'h2; bus_size = 3'd1; bus_wdata = 32'h04; bus_wr = 1'b1;
    @(negedge clk);
    eng_irq_set = 2'b00; bus_wr = 1'b0;
    rd(4'h2, 3'd1, d); chk("R8 set beats clear", d, 32'h05);
    wr(4'h2, 3'd1, 32'h0000_0004);
    rd(4'h2, 3'd1, d); chk("R6 w1c irq", d, 32'h01);

    // R11 reset again
    @(negedge clk); rst = 1'b1; eng_active = 2'b00;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    chk("R11 reset clears", {cmd_start, cmd_dir, desc_ptr}, 68'h0);
    rd(4'h2, 3'd1, d); chk("R11 status clear", d, 32'h0);
    rd(4'h8, 3'd1, d); chk("R11 cmd1 clear", d, 32'h0);
    finish_run();
  end
endmodule